// File: doc/BRIEF.md
# Compressed Branch Target Buffer

This block is a set-associative table of taken-branch targets for an instruction fetch front end. Every cycle it is given the current fetch PC. It answers in the same cycle with a hit flag and a predicted next fetch PC. A resolve port writes a branch PC and its real target whenever a taken branch is resolved. The write becomes visible to lookups from the next cycle on. Not-taken branches never need an entry, because their successor is the sequential address.

Storage is kept small in two ways:

- **Partial tag.** Each entry holds only a slice of the branch address bits above the set index. Branches that differ only in the high PC bits therefore alias onto one entry. Such aliasing is accepted as an occasional misprediction.
- **Shortened target.** Only the low target bits are stored. The predicted PC is rebuilt by placing the lookup PC's own high bits above the stored low bits. A branch whose real target leaves that window is predicted wrongly, and that loss is also accepted.

The block only reports a hit and a candidate address. Choosing the final next PC is left to the surrounding fetch logic.

Top module: `btb_compressed`

## Requirements
- R1: After reset, and after any later reset, no entry is valid and every lookup reports a miss.
- R2: A resolve write of branch PC X with target T makes a lookup of X, from the next cycle on, report a hit with pred_pc_o = {lookup PC bits [31:20], T bits [19:0]}.
- R3: The set index is PC bits [7:2] and the stored partial tag is PC bits [19:8]. PC bits [31:20] and [1:0] take no part in matching, so a lookup differing from a written PC only in those bits hits the same entry.
- R4: The high 12 bits of pred_pc_o always come from the lookup PC, never from the written target, even when the written target's high bits differ.
- R5: A lookup in the same cycle as a write to the same entry returns the contents held before that write, or a miss if the entry was not yet present.
- R6: On a miss, hit_o is 0 and pred_pc_o is all zeros.
- R7: A write whose set and tag match a valid entry rewrites that entry's target in place. It uses no other way, and at most one way of a set ever matches a given tag.
- R8: A write that misses fills the lowest-numbered invalid way of its set, so four distinct tags in one set all stay resident.
- R9: A write that misses in a full set replaces the way named by that set's round-robin pointer. Each pointer starts at way 0 after reset, steps 0,1,2,3,0 and moves only when its own set evicts.
- R10: A lookup hits only in its own set. The same partial tag written into a different set gives no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all valid bits and pointers |
| lookup_pc_i | input | 32 | Fetch PC to look up |
| hit_o | output | 1 | Lookup found a valid matching entry |
| pred_pc_o | output | 32 | Rebuilt predicted next fetch PC, zero on a miss |
| upd_valid_i | input | 1 | Resolve write strobe for a taken branch |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_target_i | input | 32 | Real target of the resolved branch |

## Verification
The bench uses the default parameters: 64 sets, 4 ways, a 32-bit PC, a 12-bit tag and a 20-bit stored target. At 256 entries, every set can be swept, every way filled and each round-robin pointer driven through a full wrap within a few thousand cycles. Writing targets whose high 12 bits differ from the lookup PC, and varying the lookup PC's high bits, brings the aliasing of R3 and the high-bit substitution of R4 into range. A seeded pseudo-random phase over four sets and eight tags then mixes allocation, in-place rewrites and evictions against an arithmetic model of the table.

// File: rtl/btb_pkg.sv
package btb_pkg;
  parameter int unsigned PC_W   = 32;
  parameter int unsigned SETS   = 64;
  parameter int unsigned WAYS   = 4;
  parameter int unsigned TAG_W  = 12;
  parameter int unsigned TGT_W  = 20;
  parameter int unsigned OFFS_W = 2;
endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int unsigned SETS  = 64,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 12,
  parameter int unsigned TGT_W = 20,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [SET_W-1:0]                rd_set_i,
  output logic [WAYS-1:0]                 rd_valid_o,
  output logic [WAYS-1:0][TAG_W-1:0]      rd_tag_o,
  output logic [WAYS-1:0][TGT_W-1:0]      rd_tgt_o,
  input  logic [SET_W-1:0]                up_set_i,
  output logic [WAYS-1:0]                 up_valid_o,
  output logic [WAYS-1:0][TAG_W-1:0]      up_tag_o,
  input  logic                            wr_en_i,
  input  logic [SET_W-1:0]                wr_set_i,
  input  logic [WAY_W-1:0]                wr_way_i,
  input  logic [TAG_W-1:0]                wr_tag_i,
  input  logic [TGT_W-1:0]                wr_tgt_i
);
  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [TGT_W-1:0] tgt_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_set_i][wr_way_i] <= 1'b1;
  end

  // payload needs no reset: gated by valid
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_set_i][wr_way_i] <= wr_tag_i;
      tgt_q[wr_set_i][wr_way_i] <= wr_tgt_i;
    end
  end

  assign rd_valid_o = valid_q[rd_set_i];
  assign up_valid_o = valid_q[up_set_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tag_o[w] = tag_q[rd_set_i][w];
    assign rd_tgt_o[w] = tgt_q[rd_set_i][w];
    assign up_tag_o[w] = tag_q[up_set_i][w];
  end

  // R2
  // write_lands_chk
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_set_i)][$past(wr_way_i)] &&
                tag_q[$past(wr_set_i)][$past(wr_way_i)] == $past(wr_tag_i) &&
                tgt_q[$past(wr_set_i)][$past(wr_way_i)] == $past(wr_tgt_i));
endmodule

// File: rtl/btb_tag_cmp.sv
module btb_tag_cmp #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 12,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            match_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_o[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int unsigned SETS = 64,
  parameter int unsigned WAYS = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic             alloc_i,
  output logic [WAY_W-1:0] way_o
);
  logic [WAY_W-1:0] rr_q [SETS];
  logic             has_free;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  assign way_o = has_free ? free_way : rr_q[set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (alloc_i && !has_free) begin
      rr_q[set_i] <= (rr_q[set_i] == WAY_W'(WAYS - 1)) ? '0 : rr_q[set_i] + 1'b1;
    end
  end

  // R8
  // free_first_chk
  free_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !(&valid_i)) |-> !valid_i[way_o]);

  // R9
  // rr_step_chk
  rr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && (&valid_i)) |=>
      rr_q[$past(set_i)] == WAY_W'((int'($past(way_o)) + 1) % int'(WAYS)));
endmodule

// File: rtl/btb_compressed.sv
module btb_compressed #(
  parameter int unsigned PC_W   = btb_pkg::PC_W,
  parameter int unsigned SETS   = btb_pkg::SETS,
  parameter int unsigned WAYS   = btb_pkg::WAYS,
  parameter int unsigned TAG_W  = btb_pkg::TAG_W,
  parameter int unsigned TGT_W  = btb_pkg::TGT_W,
  parameter int unsigned OFFS_W = btb_pkg::OFFS_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lookup_pc_i,
  output logic            hit_o,
  output logic [PC_W-1:0] pred_pc_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic [PC_W-1:0] upd_target_i
);
  localparam int unsigned SET_W  = $clog2(SETS);
  localparam int unsigned WAY_W  = $clog2(WAYS);
  localparam int unsigned TAG_LO = OFFS_W + SET_W;
  localparam int unsigned KEY_W  = SET_W + TAG_W;

  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;

  assign lk_set = lookup_pc_i[OFFS_W +: SET_W];
  assign lk_tag = lookup_pc_i[TAG_LO +: TAG_W];
  assign up_set = upd_pc_i[OFFS_W +: SET_W];
  assign up_tag = upd_pc_i[TAG_LO +: TAG_W];

  logic [WAYS-1:0]            lk_valid, up_valid, lk_match, up_match;
  logic [WAYS-1:0][TAG_W-1:0] lk_tags, up_tags;
  logic [WAYS-1:0][TGT_W-1:0] lk_tgts;
  logic [WAY_W-1:0]           lk_way, up_way, vic_way, wr_way;
  logic                       lk_hit, up_hit;

  btb_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_set_i   (lk_set),
    .rd_valid_o (lk_valid),
    .rd_tag_o   (lk_tags),
    .rd_tgt_o   (lk_tgts),
    .up_set_i   (up_set),
    .up_valid_o (up_valid),
    .up_tag_o   (up_tags),
    .wr_en_i    (upd_valid_i),
    .wr_set_i   (up_set),
    .wr_way_i   (wr_way),
    .wr_tag_i   (up_tag),
    .wr_tgt_i   (upd_target_i[TGT_W-1:0])
  );

  btb_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_cmp (
    .valid_i (lk_valid),
    .tags_i  (lk_tags),
    .tag_i   (lk_tag),
    .match_o (lk_match),
    .hit_o   (lk_hit),
    .way_o   (lk_way)
  );

  btb_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_cmp (
    .valid_i (up_valid),
    .tags_i  (up_tags),
    .tag_i   (up_tag),
    .match_o (up_match),
    .hit_o   (up_hit),
    .way_o   (up_way)
  );

  btb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (up_set),
    .valid_i (up_valid),
    .alloc_i (upd_valid_i && !up_hit),
    .way_o   (vic_way)
  );

  // rewrite in place on hit, else allocate
  assign wr_way = up_hit ? up_way : vic_way;

  assign hit_o     = lk_hit;
  assign pred_pc_o = lk_hit ? {lookup_pc_i[PC_W-1:TGT_W], lk_tgts[lk_way]} : '0;

  // R7
  // unique_match_chk
  unique_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match) && $onehot0(up_match));

  // R2
  // written_hit_chk
  written_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=>
      (lookup_pc_i[OFFS_W +: KEY_W] != $past(upd_pc_i[OFFS_W +: KEY_W])) ||
      (hit_o && pred_pc_o[TGT_W-1:0] == $past(upd_target_i[TGT_W-1:0])));
endmodule

// File: tb/tb_btb_compressed.sv
module tb_btb_compressed;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 64;
  localparam int WAYS = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lookup_pc_i = '0;
  logic        hit_o;
  logic [31:0] pred_pc_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic [31:0] upd_target_i = '0;

  btb_compressed dut (
    .clk_i, .rst_ni, .lookup_pc_i, .hit_o, .pred_pc_o,
    .upd_valid_i, .upd_pc_i, .upd_target_i
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // bench model of the table
  bit          m_v   [SETS][WAYS];
  logic [11:0] m_tag [SETS][WAYS];
  logic [19:0] m_tgt [SETS][WAYS];
  int          m_rr  [SETS];

  function automatic logic [31:0] mk_pc(input logic [11:0] hi, input logic [11:0] tag,
                                        input int set);
    return {hi, tag, set[5:0], 2'b00};
  endfunction

  task automatic model_clear();
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) m_v[s][w] = 1'b0;
    end
  endtask

  function automatic logic [32:0] model_look(input logic [31:0] pc);
    int s = int'(pc[7:2]);
    for (int w = 0; w < WAYS; w++)
      if (m_v[s][w] && m_tag[s][w] == pc[19:8]) return {1'b1, pc[31:20], m_tgt[s][w]};
    return 33'd0;
  endfunction

  task automatic model_write(input logic [31:0] pc, input logic [31:0] tgt);
    int s = int'(pc[7:2]);
    int way = -1;
    for (int w = 0; w < WAYS; w++)
      if (way < 0 && m_v[s][w] && m_tag[s][w] == pc[19:8]) way = w;
    if (way < 0)
      for (int w = 0; w < WAYS; w++)
        if (way < 0 && !m_v[s][w]) way = w;
    if (way < 0) begin
      way = m_rr[s];
      m_rr[s] = (m_rr[s] + 1) % WAYS;
    end
    m_v[s][way] = 1'b1;
    m_tag[s][way] = pc[19:8];
    m_tgt[s][way] = tgt[19:0];
  endtask

  task automatic cyc(input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                     input logic [31:0] utgt, input string req);
    logic [32:0] exp;
    @(negedge clk_i);
    lookup_pc_i = lpc; upd_valid_i = uv; upd_pc_i = upc; upd_target_i = utgt;
    #1;
    exp = model_look(lpc);
    checks++;
    if ({hit_o, pred_pc_o} !== exp) begin
      fails++;
      $display("FAIL %s pc=%h actual hit=%b pred=%h expected hit=%b pred=%h",
               req, lpc, hit_o, pred_pc_o, exp[32], exp[31:0]);
    end
    if (uv) model_write(upc, utgt);
  endtask

  task automatic sweep_all(input logic [11:0] hi, input string req);
    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < WAYS; t++)
        cyc(mk_pc(hi, 12'(s * 4 + t + 1), s), 1'b0, '0, '0, req);
  endtask

  task automatic sweep_set(input int s, input int ntag, input string req);
    for (int t = 1; t <= ntag; t++) cyc(mk_pc(12'h3C3, 12'(12'h800 + t), s), 1'b0, '0, '0, req);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 200000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d cycles expected<=200000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1, R6: empty table misses everywhere
    sweep_all(12'hABC, "R1");

    // R8: fill every way of every set; targets carry foreign high bits
    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < WAYS; t++)
        cyc(mk_pc(12'h000, 12'(s * 4 + t + 1), s), 1'b1, mk_pc(12'h000, 12'(s * 4 + t + 1), s),
            {12'h5A5, 8'(s), 10'(t), 2'b00}, "R8");
    sweep_all(12'h000, "R8");
    // R3: high PC bits ignored in matching
    sweep_all(12'hFFF, "R3");
    // R4: high bits of prediction come from lookup PC
    sweep_all(12'h123, "R4");
    // R10: tag of set 0 way 0 looked up in set 5 misses
    cyc(mk_pc(12'h000, 12'd1, 5), 1'b0, '0, '0, "R10");
    cyc(mk_pc(12'h000, 12'd5, 0), 1'b0, '0, '0, "R10");

    // R5: same-cycle lookup and rewrite sees the old target
    cyc(mk_pc(12'h000, 12'd13, 3), 1'b1, mk_pc(12'h000, 12'd13, 3), 32'h000F_EED0, "R5");
    // R7: new target visible next cycle, other ways intact
    cyc(mk_pc(12'h000, 12'd13, 3), 1'b0, '0, '0, "R7");
    for (int t = 0; t < WAYS; t++) cyc(mk_pc(12'h000, 12'(12 + t + 1), 3), 1'b0, '0, '0, "R7");

    // R9: eviction order in a fresh set after reset
    @(negedge clk_i); rst_ni = 1'b0; model_clear();
    @(negedge clk_i); rst_ni = 1'b1;
    sweep_all(12'h000, "R1");
    for (int t = 1; t <= 10; t++) begin
      cyc(mk_pc(12'h3C3, 12'(12'h800 + t), 10), 1'b1, mk_pc(12'h000, 12'(12'h800 + t), 10),
          32'h0001_0000 + 32'(t * 4), "R9");
      sweep_set(10, 10, "R9");
      sweep_set(11, 2, "R9");
    end
    // R5: lookup of entry being allocated this cycle still misses
    cyc(mk_pc(12'h000, 12'h0AA, 20), 1'b1, mk_pc(12'h000, 12'h0AA, 20), 32'h0000_1234, "R5");
    cyc(mk_pc(12'h000, 12'h0AA, 20), 1'b0, '0, '0, "R5");

    // R2: pseudo-random mix over a small pool
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] lpc, upc, tgt;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lpc = mk_pc(12'(lfsr[15:12]), 12'(lfsr[2:0]), int'(lfsr[4:3]));
      upc = mk_pc(12'(lfsr[11:9]), 12'(lfsr[7:5]), int'(lfsr[9:8]));
      tgt = {lfsr, lfsr[7:0], lfsr[15:8]};
      cyc(lpc, lfsr[11], upc, tgt, "R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule